// File: doc/BRIEF.md
# Checkerboard Colour Dither for One-Bit Channels

This block sits between a pixel source and a display output that carries a single bit per colour channel. For each of red, green and blue the source supplies a three-level intensity (off, half, full) together with the pixel column, the pixel row and a pulse that marks the start of a frame. The block returns one bit per channel for that pixel, one clock later.

A channel at zero or full intensity is passed through as a steady 0 or 1. A channel at half intensity is split over each 2x2 group of pixels. The "on" value goes to one diagonal of the group and the "off" value to the other. The diagonals swap on every frame, so the viewer sees an average of the two. The three channels are handled independently, so the whole pixel shows one of 27 colours instead of 8. The cost is half the effective resolution in each direction.

The phase that picks a diagonal is the XOR of the column's low bit, the row's low bit and a frame parity bit. The parity flips on each frame-start pulse. The new value already applies to the pixel presented in the same cycle as the pulse, so one frame never mixes two phases.

Top module: `colorDither`

## Requirements
- R1: While reset (rstN low) is asserted, and in the cycle after it, dOut is 3'b000. The frame parity restarts at 0.
- R2: A channel code of 2'b00 (off) drives that channel's output bit to 0 for every coordinate and frame parity.
- R3: A channel code of 2'b10 (full) drives that channel's output bit to 1 for every coordinate and frame parity.
- R4: The code 2'b11 gives the same output as 2'b10 (full).
- R5: A channel code of 2'b01 (half) drives that channel's bit to 1 when pixX[0] ^ pixY[0] ^ parity is 0, and to 0 otherwise.
- R6: The frame parity inverts on each cycle with frameStart high. The pixel presented in that same cycle already uses the inverted parity.
- R7: dOut reflects the inputs sampled at the previous rising clock edge (one cycle of latency).
- R8: pixColor packs red in bits [5:4], green in [3:2] and blue in [1:0]. dOut[2] is red, dOut[1] is green and dOut[0] is blue. Each channel is independent of the other two.
- R9: Only bit 0 of pixX and bit 0 of pixY affect the output. All higher coordinate bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous active-low reset |
| frameStart | input | 1 | One-cycle pulse marking the first pixel of a frame |
| pixX | input | XW (11) | Pixel column |
| pixY | input | YW (10) | Pixel row |
| pixColor | input | 6 | Three 2-bit channel codes: R[5:4], G[3:2], B[1:0] |
| dOut | output | 3 | One bit per channel: R[2], G[1], B[0] |

## Verification
Two functions can fall in the same cycle: the parity flip and the phase selection for a half-intensity pixel. This happens when the frame-start pulse arrives together with a pixel whose channels are at half level. The bench provokes this case with directed steps at every combination of the coordinate low bits, and also with random pulses that land on random pixels. It judges the result against a model in which the pulse's own pixel already uses the flipped parity. The same pixels also carry random higher coordinate bits, which shows that only the low bits select the diagonal.

// File: rtl/ditherPkg.sv
package ditherPkg;
  localparam int CHANNELS = 3;
  localparam int LEVEL_W  = 2;
  localparam int COLOR_W  = CHANNELS * LEVEL_W;

  // Strobes from control to datapath
  typedef struct packed {
    logic showSecond;  // pick the second colour bit for this pixel
    logic parity;      // frame parity in force for this pixel
  } ditherStrobe_t;

  // first colour: lit for half or full
  function automatic logic firstBit(input logic [LEVEL_W-1:0] code);
    return |code;
  endfunction

  // second colour: lit only for full (2'b10, 2'b11)
  function automatic logic secondBit(input logic [LEVEL_W-1:0] code);
    return code[LEVEL_W-1];
  endfunction
endpackage

// File: rtl/ditherCtrl.sv
module ditherCtrl
  import ditherPkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          frameStart,
  input  logic          xLsb,
  input  logic          yLsb,
  output ditherStrobe_t strobe
);
  logic parityReg;
  logic parityNow;

  // The frame-start pixel already uses the flipped parity (R6)
  assign parityNow = parityReg ^ frameStart;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) parityReg <= 1'b0;
    else       parityReg <= parityNow;
  end

  always_comb begin
    strobe.parity     = parityNow;
    strobe.showSecond = xLsb ^ yLsb ^ parityNow;
  end
endmodule

// File: rtl/ditherPath.sv
module ditherPath
  import ditherPkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  ditherStrobe_t       strobe,
  input  logic [COLOR_W-1:0]  pixColor,
  output logic [CHANNELS-1:0] dOut
);
  logic [CHANNELS-1:0] nextOut;

  for (genvar ch = 0; ch < CHANNELS; ch++) begin : g_chan
    logic [LEVEL_W-1:0] code;
    assign code = pixColor[ch*LEVEL_W +: LEVEL_W];
    assign nextOut[ch] = strobe.showSecond ? secondBit(code) : firstBit(code);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) dOut <= '0;
    else       dOut <= nextOut;
  end
endmodule

// File: rtl/colorDither.sv
module colorDither #(
  parameter int XW = 11,
  parameter int YW = 10
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          frameStart,
  input  logic [XW-1:0] pixX,
  input  logic [YW-1:0] pixY,
  input  logic [5:0]    pixColor,
  output logic [2:0]    dOut
);
  import ditherPkg::*;

  ditherStrobe_t strobe;

  ditherCtrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .frameStart(frameStart),
    .xLsb      (pixX[0]),
    .yLsb      (pixY[0]),
    .strobe    (strobe)
  );

  ditherPath u_path (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .pixColor(pixColor),
    .dOut    (dOut)
  );
endmodule

// File: rtl/ditherChecker.sv
module ditherChecker #(
  parameter int XW = 11,
  parameter int YW = 10
) (
  input logic          clk,
  input logic          rstN,
  input logic          frameStart,
  input logic [XW-1:0] pixX,
  input logic [YW-1:0] pixY,
  input logic [5:0]    pixColor,
  input logic [2:0]    dOut
);
  // Independent parity tracker for the checks
  logic refParity;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           refParity <= 1'b0;
    else if (frameStart) refParity <= ~refParity;
  end

  logic refPhase;
  assign refPhase = pixX[0] ^ pixY[0] ^ (frameStart ? ~refParity : refParity);

  p_reset_r1: assert property (@(posedge clk) !rstN |=> dOut == 3'b000);

  p_off_red_r2: assert property (@(posedge clk) disable iff (!rstN)
    pixColor[5:4] == 2'b00 |=> dOut[2] == 1'b0);

  p_full_green_r3: assert property (@(posedge clk) disable iff (!rstN)
    pixColor[3:2] == 2'b10 |=> dOut[1] == 1'b1);

  p_code11_blue_r4: assert property (@(posedge clk) disable iff (!rstN)
    pixColor[1:0] == 2'b11 |=> dOut[0] == 1'b1);

  // R5 / R6: half level follows the phase including the flip on the pulse pixel
  p_half_green_r5: assert property (@(posedge clk) disable iff (!rstN)
    pixColor[3:2] == 2'b01 |=> dOut[1] == ~$past(refPhase));
endmodule

bind colorDither ditherChecker #(.XW(XW), .YW(YW)) i_ditherChecker (
  .clk       (clk),
  .rstN      (rstN),
  .frameStart(frameStart),
  .pixX      (pixX),
  .pixY      (pixY),
  .pixColor  (pixColor),
  .dOut      (dOut)
);

// File: tb/test_colorDither.sv
module test_colorDither;
  localparam int XW = 11;
  localparam int YW = 10;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          frameStart = 1'b0;
  logic [XW-1:0] pixX = '0;
  logic [YW-1:0] pixY = '0;
  logic [5:0]    pixColor = '0;
  logic [2:0]    dOut;

  int compared = 0;
  int mismatched = 0;
  logic tbParity = 1'b0;
  bit done = 0;

  colorDither #(.XW(XW), .YW(YW)) i_colorDither (.*);

  always #10 clk = ~clk;  // 50 MHz

  // Expected bit for one channel code at a given phase
  function automatic logic expBit(input logic [1:0] code, input logic phase);
    if (code == 2'b00) return 1'b0;
    if (code[1])       return 1'b1;
    return ~phase;  // half: lit when phase is 0
  endfunction

  function automatic logic [2:0] expOut(input logic [5:0] col, input logic phase);
    return {expBit(col[5:4], phase), expBit(col[3:2], phase), expBit(col[1:0], phase)};
  endfunction

  task automatic check(input string req, input logic [2:0] exp);
    compared++;
    if (dOut !== exp) begin
      mismatched++;
      $display("FAIL %s: dOut=%b expected=%b", req, dOut, exp);
    end
  endtask

  // Drive one pixel at a negedge, check it one cycle later (R7)
  task automatic step(input string req, input logic [5:0] col,
                      input logic [XW-1:0] x, input logic [YW-1:0] y, input logic fs);
    logic [2:0] exp;
    pixColor = col; pixX = x; pixY = y; frameStart = fs;
    if (fs) tbParity = ~tbParity;
    exp = expOut(col, x[0] ^ y[0] ^ tbParity);
    @(posedge clk);
    @(negedge clk);
    frameStart = 1'b0;
    check(req, exp);
  endtask

  initial begin
    void'($urandom(32'h5EED_D17E));
    repeat (3) @(negedge clk);
    check("R1 in reset", 3'b000);
    rstN = 1'b1;
    check("R1 after release", 3'b000);

    // Parity 0 after reset: half everywhere at phase 0 and 1 (R5)
    step("R5 half phase0", 6'b010101, 11'd0, 10'd0, 1'b0);
    step("R5 half phase1", 6'b010101, 11'd1, 10'd0, 1'b0);
    step("R5 half diag", 6'b010101, 11'd1, 10'd1, 1'b0);
    // Off and full (R2, R3)
    step("R2 off", 6'b000000, 11'd0, 10'd0, 1'b0);
    step("R3 full", 6'b101010, 11'd1, 10'd0, 1'b0);
    // Code 11 (R4)
    step("R4 code11", 6'b111111, 11'd1, 10'd0, 1'b0);
    // Mixed channels (R8): red full, green half, blue off at phase 1 -> 100
    step("R8 mixed", 6'b100100, 11'd0, 10'd1, 1'b0);
    step("R8 mixed2", 6'b010010, 11'd0, 10'd0, 1'b0);
    // High coordinate bits ignored (R9)
    step("R9 highbits", 6'b010101, 11'h7FE, 10'h3FE, 1'b0);
    step("R9 highbits2", 6'b010101, 11'h555, 10'h2AA, 1'b0);
    // Pulse and pixel in the same cycle (R6)
    for (int i = 0; i < 4; i++)
      step("R6 pulse pixel", 6'b010101, XW'(i & 1), YW'(i >> 1), 1'b1);
    step("R6 after pulse", 6'b010101, 11'd0, 10'd0, 1'b0);

    // Random mix (R2-R9)
    for (int i = 0; i < 3000; i++) begin
      logic [5:0] c;
      c = 6'($urandom);
      step("R5 random", c, XW'($urandom), YW'($urandom), ($urandom % 37) == 0);
    end

    // Reset mid-run restarts parity (R1)
    @(negedge clk);
    rstN = 1'b0;
    #1 check("R1 async reset", 3'b000);
    @(negedge clk);
    rstN = 1'b1;
    tbParity = 1'b0;
    step("R1 parity restart", 6'b010101, 11'd0, 10'd0, 1'b0);

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        compared++;
        mismatched++;
        $display("FAIL watchdog: run did not complete");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule